// File: doc/BRIEF.md
# Register-mapped serial port with receive and transmit queues

This block is a serial port for an on-chip word bus. Software writes a character to the transmit data word. The character goes into an 8-entry transmit queue. A transmitter drains the queue and sends each character as an 8N1 frame on `txd_o`. A receiver watches `rxd_i`, recovers frames and places each character in an 8-entry receive queue. Software takes characters out by reading the receive data word.

Queue status is not held in separate status words. Bit 31 of the transmit data word reads 1 when the transmit queue is full. Bit 31 of the receive data word reads 1 when there is nothing to read. A read of the receive data word that finds data returns the character and removes it from the queue in the same access.

The bit rate is set by a divisor register. One bit lasts divisor + 1 clock cycles. Each direction has its own enable. A receive-watermark flag can raise an interrupt.

Top module: `uart_mmio`

## Requirements
- R1: The registers are word indices on `addr_i`: 0 transmit data, 1 receive data, 2 transmit control, 3 receive control, 4 interrupt enable, 5 interrupt pending, 6 divisor. A read of index 7 returns 0.
- R2: A read of index 0 returns bit 31 = 1 when the transmit queue holds 8 entries, and 0 otherwise. A write to index 0 queues `wdata_i[7:0]` as one character. A write while the queue is full is dropped.
- R3: A read of index 1 with an empty receive queue returns 32'h8000_0000 and leaves the queue unchanged. A read of index 1 with data returns the oldest character in bits 7:0, with bit 31 = 0, and removes that character.
- R4: Bit 0 of index 2 enables the transmitter. While it is 0, queued characters wait and `txd_o` stays high. Setting it sends them in write order.
- R5: Bit 0 of index 3 enables the receiver. Frames that arrive while it is 0 are not queued.
- R6: Bit 1 of index 5 reads 1 exactly when the receive queue is not empty. Index 5 is read-only: writes to it have no effect.
- R7: `irq_o` is the OR of (pending bits AND enable bits of index 4). Writing 0 to index 4 forces `irq_o` low.
- R8: Index 6 holds a 16-bit divisor that resets to 4. Each serial bit lasts divisor + 1 clocks, so a divisor of 0 sends one bit per clock.
- R9: A frame is a low start bit, then 8 data bits least significant first, then a high stop bit. The line idles high.
- R10: The receiver samples each bit near its middle. A frame whose stop bit is sampled low is discarded, and the receiver waits for the line to return high before it looks for a new start bit.
- R11: Both queues are 8 deep. A frame received while the receive queue is full is dropped, and the 8 characters already queued stay intact.
- R12: After reset, `txd_o` is 1, `irq_o` is 0, both enables are 0 and both queues are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| rxd_i | input | 1 | Serial input |
| txd_o | output | 1 | Serial output |
| irq_o | output | 1 | Interrupt request |

## Verification
Two events can meet on each queue in the same cycle: a software push and the transmitter's pop on the transmit side, and the receiver's push and a software read on the receive side. The bench provokes the transmit-side collision by streaming characters. It polls the full flag and writes again as soon as a slot frees, so new writes land while the transmitter is taking entries. A scoreboard queue of expected characters is compared, in order, against frames decoded from `txd_o`. Any loss, duplicate or reordering shows up as a mismatch or as an unexpected character. On the receive side, a burst of nine frames against a full queue, and reads that find the queue empty, are judged through the values that later reads return.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;
  localparam int REG_AW  = 3;
  localparam int CHAR_W  = 8;
  localparam int STAT_B  = 31;
  localparam int WM_B    = 1;

  typedef enum logic [REG_AW-1:0] {
    A_TXDATA = 3'd0,
    A_RXDATA = 3'd1,
    A_TXCTRL = 3'd2,
    A_RXCTRL = 3'd3,
    A_IE     = 3'd4,
    A_IP     = 3'd5,
    A_DIV    = 3'd6,
    A_NONE   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  p_count_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_full_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (cnt_q == $past(cnt_q)));
  p_empty_pop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> $stable(rptr_q) && empty_o);
endmodule

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= keeps the period bounded if the divisor shrinks mid-count
  assign tick_o = !clear_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i || tick_o)  cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o || clear_i) |=> (cnt_q == '0));
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_mmio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              q_empty_i,
  input  logic [CHAR_W-1:0] q_data_i,
  output logic              q_pop_o,
  output logic              busy_o,
  output logic              txd_o
);
  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_st_e;

  tx_st_e            st_q;
  logic [CHAR_W-1:0] sh_q;
  logic [2:0]        idx_q;
  logic              txd_q;

  assign q_pop_o = (st_q == TX_IDLE) && en_i && !q_empty_i;
  assign busy_o  = (st_q != TX_IDLE);
  assign txd_o   = txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= TX_IDLE;
      sh_q  <= '0;
      idx_q <= '0;
      txd_q <= 1'b1;
    end else begin
      case (st_q)
        TX_IDLE: begin
          txd_q <= 1'b1;
          if (q_pop_o) begin
            sh_q  <= q_data_i;
            txd_q <= 1'b0;
            st_q  <= TX_START;
          end
        end
        TX_START: if (tick_i) begin
          txd_q <= sh_q[0];
          sh_q  <= sh_q >> 1;
          idx_q <= '0;
          st_q  <= TX_DATA;
        end
        TX_DATA: if (tick_i) begin
          if (idx_q == 3'd7) begin
            txd_q <= 1'b1;
            st_q  <= TX_STOP;
          end else begin
            txd_q <= sh_q[0];
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 1'b1;
          end
        end
        TX_STOP: if (tick_i) st_q <= TX_IDLE;
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  p_idle_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_IDLE) |-> txd_o);
  p_start_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_START) |-> !txd_o);
  p_hold_disabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_IDLE && !en_i) |=> (st_q == TX_IDLE));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_mmio_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              rxd_i,
  output logic              push_o,
  output logic [CHAR_W-1:0] data_o
);
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK} rx_st_e;

  rx_st_e            st_q;
  logic [1:0]        sync_q;
  logic              line;
  logic [DIV_W-1:0]  cnt_q, half;
  logic [2:0]        idx_q;
  logic [CHAR_W-1:0] sh_q;

  assign line   = sync_q[1];
  assign half   = div_i >> 1;
  assign push_o = (st_q == RX_STOP) && (cnt_q == '0) && line;
  assign data_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
    end else if (!en_i) begin
      st_q <= RX_IDLE;
    end else begin
      case (st_q)
        RX_IDLE: if (!line) begin
          idx_q <= '0;
          if (half == '0) begin
            cnt_q <= div_i;
            st_q  <= RX_DATA;
          end else begin
            cnt_q <= half - 1'b1;
            st_q  <= RX_START;
          end
        end
        RX_START: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (line)   st_q  <= RX_IDLE;   // glitch, not a start bit
          else begin
            cnt_q <= div_i;
            st_q  <= RX_DATA;
          end
        end
        RX_DATA: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else begin
            sh_q  <= {line, sh_q[CHAR_W-1:1]};
            cnt_q <= div_i;
            if (idx_q == 3'd7) st_q <= RX_STOP;
            else               idx_q <= idx_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else             st_q  <= line ? RX_IDLE : RX_BREAK;
        end
        RX_BREAK: if (line) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  p_disabled_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (st_q == RX_IDLE) && !push_o);
  p_break_wait_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_BREAK && en_i && !line) |=> (st_q == RX_BREAK));
endmodule

// File: rtl/uart_mmio.sv
module uart_mmio
  import uart_mmio_pkg::*;
#(
  parameter int                   FIFO_DEPTH = 8,
  parameter int                   DIV_W      = 16,
  parameter logic [DIV_W-1:0]     DIV_RST    = 16'd4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rxd_i,
  output logic        txd_o,
  output logic        irq_o
);
  logic             tx_en_q, rx_en_q;
  logic [1:0]       ie_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       ip;

  logic              tx_push, tx_pop, tx_full, tx_empty, tx_busy, tick;
  logic [CHAR_W-1:0] tx_head;
  logic              rx_push, rx_pop, rx_full, rx_empty;
  logic [CHAR_W-1:0] rx_head, rx_char;
  logic              wr, rd;
  reg_addr_e         ra;

  assign ra      = reg_addr_e'(addr_i);
  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign tx_push = wr && (ra == A_TXDATA);
  assign rx_pop  = rd && (ra == A_RXDATA);

  assign ip      = {!rx_empty, 1'b0};
  assign irq_o   = |(ip & ie_q);

  logic unused_w;
  assign unused_w = ^{rx_full, wdata_i[31:DIV_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      ie_q    <= '0;
      div_q   <= DIV_RST;
    end else if (wr) begin
      case (ra)
        A_TXCTRL: tx_en_q <= wdata_i[0];
        A_RXCTRL: rx_en_q <= wdata_i[0];
        A_IE:     ie_q    <= wdata_i[1:0];
        A_DIV:    div_q   <= wdata_i[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (ra)
      A_TXDATA: rdata_o[STAT_B] = tx_full;
      A_RXDATA: begin
        if (rx_empty) rdata_o[STAT_B] = 1'b1;
        else          rdata_o[CHAR_W-1:0] = rx_head;
      end
      A_TXCTRL: rdata_o[0]   = tx_en_q;
      A_RXCTRL: rdata_o[0]   = rx_en_q;
      A_IE:     rdata_o[1:0] = ie_q;
      A_IP:     rdata_o[1:0] = ip;
      A_DIV:    rdata_o[DIV_W-1:0] = div_q;
      default: ;
    endcase
  end

  uart_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .push_i(tx_push), .wdata_i(wdata_i[CHAR_W-1:0]),
    .pop_i(tx_pop), .rdata_o(tx_head),
    .full_o(tx_full), .empty_o(tx_empty)
  );

  uart_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .push_i(rx_push), .wdata_i(rx_char),
    .pop_i(rx_pop), .rdata_o(rx_head),
    .full_o(rx_full), .empty_o(rx_empty)
  );

  uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni,
    .clear_i(!tx_busy), .div_i(div_q), .tick_o(tick)
  );

  uart_tx u_tx (
    .clk_i, .rst_ni,
    .en_i(tx_en_q), .tick_i(tick),
    .q_empty_i(tx_empty), .q_data_i(tx_head),
    .q_pop_o(tx_pop), .busy_o(tx_busy), .txd_o(txd_o)
  );

  uart_rx #(.DIV_W(DIV_W)) u_rx (
    .clk_i, .rst_ni,
    .en_i(rx_en_q), .div_i(div_q), .rxd_i(rxd_i),
    .push_o(rx_push), .data_o(rx_char)
  );

  p_irq_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q == '0) |-> !irq_o);
  p_empty_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop && rx_empty) |-> (rdata_o == 32'h8000_0000));
  p_tx_full_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && ra == A_TXDATA) |-> (rdata_o[STAT_B] == tx_full));
endmodule

// File: tb/tb_uart_mmio.sv
module tb_uart_mmio;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rxd = 1'b1;
  logic        txd, irq;

  int checks = 0, fails = 0;
  int bit_p = 5;
  bit done = 1'b0;
  logic [7:0] sb_q[$];

  always #4 clk = ~clk;

  uart_mmio dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic put_char(input logic [7:0] c);
    wr(3'd0, {24'h0, c});
    sb_q.push_back(c);
  endtask

  task automatic send_frame(input logic [7:0] c, input bit stop);
    @(negedge clk);
    rxd = 0; repeat (bit_p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = c[i]; repeat (bit_p) @(negedge clk);
    end
    rxd = stop; repeat (bit_p) @(negedge clk);
    rxd = 1; repeat (4 * bit_p) @(negedge clk);
  endtask

  task automatic drain();
    int t = 0;
    while (sb_q.size() != 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (2 * bit_p + 6) @(negedge clk);
    chk(sb_q.size() == 0, "R4 queued chars sent", sb_q.size(), 0);
  endtask

  // monitor: decode frames on txd and compare against the scoreboard (R9)
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        repeat (bit_p / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (bit_p) @(negedge clk);
          b[i] = txd;
        end
        repeat (bit_p) @(negedge clk);
        chk(txd === 1'b1, "R9 stop bit high", {31'h0, txd}, 1);
        if (sb_q.size() == 0) chk(0, "R2 unexpected char", {24'h0, b}, 0);
        else begin
          logic [7:0] e;
          e = sb_q.pop_front();
          chk(b == e, "R9 tx char order/value", {24'h0, b}, {24'h0, e});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R12 / R1 reset state and map
    chk(txd === 1'b1, "R12 txd idle", {31'h0, txd}, 1);
    chk(irq === 1'b0, "R12 irq low", {31'h0, irq}, 0);
    rd(3'd0, d); chk(d == 32'h0, "R2 tx not full", d, 32'h0);
    rd(3'd1, d); chk(d == 32'h8000_0000, "R3 rx empty", d, 32'h8000_0000);
    rd(3'd2, d); chk(d == 32'h0, "R12 tx ctrl", d, 0);
    rd(3'd3, d); chk(d == 32'h0, "R12 rx ctrl", d, 0);
    rd(3'd5, d); chk(d == 32'h0, "R6 ip reset", d, 0);
    rd(3'd6, d); chk(d == 32'd4, "R8 divisor reset", d, 4);
    rd(3'd7, d); chk(d == 32'h0, "R1 unmapped", d, 0);

    // R2/R4: fill while disabled, overflow dropped, line stays idle
    wr(3'd6, 32'd3); bit_p = 4;
    rd(3'd6, d); chk(d == 32'd3, "R1 divisor readback", d, 3);
    for (int i = 0; i < 8; i++) put_char(8'h30 + 8'(i));
    rd(3'd0, d); chk(d[31] == 1'b1, "R2 full flag", d, 32'h8000_0000);
    wr(3'd0, 32'h0000_00EE);
    hi = 1;
    repeat (60) begin @(negedge clk); if (txd !== 1'b1) hi = 0; end
    chk(hi, "R4 line idle while disabled", {31'h0, hi}, 1);
    wr(3'd2, 32'h1);
    drain();

    // streaming: writes collide with transmitter pops
    for (int i = 0; i < 12; i++) begin
      d = 32'h8000_0000;
      while (d[31]) rd(3'd0, d);
      put_char((i % 2 == 0) ? (8'h01 << (i % 8)) : (8'hA5 ^ 8'(i)));
    end
    drain();

    // R8: divisor 0, one bit per clock
    wr(3'd6, 32'd0); bit_p = 1;
    put_char(8'h80); put_char(8'h01); put_char(8'h5A);
    drain();
    wr(3'd6, 32'd3); bit_p = 4;

    // R5: receiver disabled ignores frames
    send_frame(8'h77, 1);
    rd(3'd1, d); chk(d == 32'h8000_0000, "R5 rx disabled ignores", d, 32'h8000_0000);

    // R6/R7/R3 receive path
    wr(3'd3, 32'h1);
    send_frame(8'hA5, 1);
    rd(3'd5, d); chk(d == 32'h2, "R6 watermark set", d, 2);
    chk(irq === 1'b0, "R7 masked irq", {31'h0, irq}, 0);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d); chk(d == 32'h2, "R6 ip read-only", d, 2);
    wr(3'd4, 32'h2);
    chk(irq === 1'b1, "R7 irq enabled", {31'h0, irq}, 1);
    wr(3'd4, 32'h0);
    chk(irq === 1'b0, "R7 ie zero masks", {31'h0, irq}, 0);
    wr(3'd4, 32'h2);
    rd(3'd1, d); chk(d == 32'hA5, "R3 rx char", d, 32'hA5);
    rd(3'd5, d); chk(d == 32'h0, "R6 watermark clear", d, 0);
    chk(irq === 1'b0, "R7 irq drops", {31'h0, irq}, 0);
    rd(3'd1, d); chk(d == 32'h8000_0000, "R3 empty again", d, 32'h8000_0000);

    // R10: bad stop bit discarded, next frame still received
    send_frame(8'h3C, 0);
    rd(3'd1, d); chk(d == 32'h8000_0000, "R10 bad stop dropped", d, 32'h8000_0000);
    send_frame(8'hC3, 1);
    rd(3'd1, d); chk(d == 32'hC3, "R10 recovery after break", d, 32'hC3);

    // R11: nine frames into an 8-deep queue
    for (int i = 0; i < 9; i++) send_frame(8'h10 + 8'(i), 1);
    for (int i = 0; i < 8; i++) begin
      rd(3'd1, d); chk(d == 32'h10 + i, "R11 rx order kept", d, 32'h10 + i);
    end
    rd(3'd1, d); chk(d == 32'h8000_0000, "R11 ninth dropped", d, 32'h8000_0000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule